// File: doc/BRIEF.md
# Set/Clear GPIO Port

A memory-mapped general-purpose I/O port of 32 pins. Software never has to read, modify and write back a register to move one pin: the output level of each pin is raised through one write-one-to-set register and lowered through a separate write-one-to-clear register. The output driver of each pin is handled the same way, with one register that switches drivers on and another that releases them to high impedance. Bits written as zero leave their pins untouched, so independent software agents can each control their own pins without locking.

The current level of every pin is read back through an input register. Each pin input passes through a two-flop synchroniser first, so the read value is safe to use even though the pins are asynchronous to the bus clock. The bus is a plain 32-bit register interface with address, write enable, write data and combinational read data. Pin n always maps to bit n of every register.

Register offsets (byte addresses on an 8-bit address bus): 0x00 raises levels, 0x10 lowers levels, 0x20 enables drivers, 0x30 releases drivers, and 0x40 returns the synchronised pin levels. Reading 0x00 returns the level vector and reading 0x20 returns the enable vector. Every other address reads as zero and ignores writes.

Top module: `setclr_gpio_port`

## Requirements
- R1: While reset is asserted and after it is released, `pin_out` and `pin_oe` are all zero until the first register write.
- R2: A write to offset 0x00 sets to 1 every `pin_out` bit whose write-data bit is 1 and leaves the other bits unchanged, visible after the clock edge that takes the write.
- R3: A write to offset 0x10 clears to 0 every `pin_out` bit whose write-data bit is 1 and leaves the other bits unchanged, visible after the clock edge that takes the write.
- R4: A write to offset 0x20 sets to 1 every `pin_oe` bit whose write-data bit is 1 and leaves the other bits unchanged.
- R5: A write to offset 0x30 clears to 0 every `pin_oe` bit whose write-data bit is 1 and leaves the other bits unchanged.
- R6: A read of offset 0x40 returns `pin_in` as it was two rising clock edges earlier, for every pin, whether its driver is enabled or not.
- R7: In the same cycle as the address is presented, a read of offset 0x00 returns `pin_out` and a read of offset 0x20 returns `pin_oe`.
- R8: Reads of 0x10, 0x30 and every address other than 0x00, 0x20 and 0x40 return zero; writes to 0x40 or to any address other than 0x00, 0x10, 0x20 and 0x30 change neither `pin_out` nor `pin_oe`.
- R9: Writes to 0x00 and 0x10 never change `pin_oe`, and writes to 0x20 and 0x30 never change `pin_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register byte address |
| reg_wen | input | 1 | Write strobe, taken on the rising clock edge |
| reg_wdata | input | 32 | Write data, bit n acts on pin n |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output level per pin |
| pin_oe | output | 32 | Output driver enable per pin, 1 drives |

## Verification
Level and enable updates are due one rising edge after the write is presented, read data is due in the same cycle as its address, and a change on `pin_in` reaches the 0x40 read value only after exactly two rising edges. The bench drives every input on the falling edge and samples just after it, so a write check looks at the outputs half a period after the edge that took the write. The input path is checked three times per change, before the first edge, after the first and after the second, so that both a missing and an extra synchroniser stage are reported. The sweeps cover a walking one on every pin through all four update registers, pseudo-random masks, and all 256 addresses for both reads and ignored writes.

// File: rtl/sgp_pkg.sv
package sgp_pkg;

    localparam int unsigned OFS_LVL_SET = 32'h00;
    localparam int unsigned OFS_LVL_CLR = 32'h10;
    localparam int unsigned OFS_DRV_ON  = 32'h20;
    localparam int unsigned OFS_DRV_OFF = 32'h30;
    localparam int unsigned OFS_PINS    = 32'h40;

    typedef enum logic [1:0] {
        RSEL_NONE  = 2'd0,
        RSEL_LEVEL = 2'd1,
        RSEL_DRIVE = 2'd2,
        RSEL_PINS  = 2'd3
    } rsel_e;

    typedef struct packed {
        logic lvl_set;
        logic lvl_clr;
        logic drv_on;
        logic drv_off;
    } wstb_t;

endpackage

// File: rtl/sgp_decode.sv
module sgp_decode
    import sgp_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wen,
    output wstb_t             wstb,
    output rsel_e             rsel
);

    always_comb begin
        wstb = '0;
        rsel = RSEL_NONE;
        unique case (addr)
            ADDR_W'(OFS_LVL_SET): begin
                wstb.lvl_set = wen;
                rsel         = RSEL_LEVEL;
            end
            ADDR_W'(OFS_LVL_CLR): begin
                wstb.lvl_clr = wen;
            end
            ADDR_W'(OFS_DRV_ON): begin
                wstb.drv_on = wen;
                rsel        = RSEL_DRIVE;
            end
            ADDR_W'(OFS_DRV_OFF): begin
                wstb.drv_off = wen;
            end
            ADDR_W'(OFS_PINS): begin
                rsel = RSEL_PINS;
            end
            default: begin
                rsel = RSEL_NONE;
            end
        endcase
    end

endmodule

// File: rtl/sgp_w1sc.sv
module sgp_w1sc #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [W-1:0] mask,
    output logic [W-1:0] q
);

    logic [W-1:0] q_r;

    // One flop per pin; a set strobe wins over a clear strobe.
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q_r[i] <= 1'b0;
            end else if (set_stb && mask[i]) begin
                q_r[i] <= 1'b1;
            end else if (clr_stb && mask[i]) begin
                q_r[i] <= 1'b0;
            end
        end
    end

    assign q = q_r;

    // R2/R4: unmasked bits keep their value across any strobe
    assert_unmasked_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_stb || clr_stb) |=> ((q & ~$past(mask)) == ($past(q) & ~$past(mask))));

endmodule

// File: rtl/sgp_sync.sv
module sgp_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];
    logic         warm_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
            // R6: each stage carries the previous one forward by one edge
            assert_sync_chain_R6: assert property (@(posedge clk) disable iff (!rst_n)
                warm_q |-> (stg[s] == $past(stg[s-1])));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) warm_q <= 1'b0;
        else        warm_q <= 1'b1;
    end

    assign q = stg[STAGES-1];

    // R6: the first stage captures the pin one edge late
    assert_sync_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        warm_q |-> (stg[0] == $past(d)));

    initial begin
        assert_sync_depth_R6: assert (STAGES >= 2);
    end

endmodule

// File: rtl/setclr_gpio_port.sv
module setclr_gpio_port
    import sgp_pkg::*;
#(
    parameter int unsigned PIN_W       = 32,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wen,
    input  logic [PIN_W-1:0]  reg_wdata,
    output logic [PIN_W-1:0]  reg_rdata,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out,
    output logic [PIN_W-1:0]  pin_oe
);

    wstb_t            wstb;
    rsel_e            rsel;
    logic [PIN_W-1:0] lvl_q;
    logic [PIN_W-1:0] drv_q;
    logic [PIN_W-1:0] pins_sync;

    sgp_decode #(
        .ADDR_W (ADDR_W)
    ) u_decode (
        .addr (reg_addr),
        .wen  (reg_wen),
        .wstb (wstb),
        .rsel (rsel)
    );

    sgp_w1sc #(
        .W (PIN_W)
    ) u_level (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (wstb.lvl_set),
        .clr_stb (wstb.lvl_clr),
        .mask    (reg_wdata),
        .q       (lvl_q)
    );

    sgp_w1sc #(
        .W (PIN_W)
    ) u_drive (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (wstb.drv_on),
        .clr_stb (wstb.drv_off),
        .mask    (reg_wdata),
        .q       (drv_q)
    );

    sgp_sync #(
        .W      (PIN_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pins_sync)
    );

    assign pin_out = lvl_q;
    assign pin_oe  = drv_q;

    always_comb begin
        unique case (rsel)
            RSEL_LEVEL: reg_rdata = lvl_q;
            RSEL_DRIVE: reg_rdata = drv_q;
            RSEL_PINS:  reg_rdata = pins_sync;
            default:    reg_rdata = '0;
        endcase
    end

    logic wr_lvl_set, wr_lvl_clr, wr_drv_on, wr_drv_off;
    assign wr_lvl_set = reg_wen && (reg_addr == ADDR_W'(OFS_LVL_SET));
    assign wr_lvl_clr = reg_wen && (reg_addr == ADDR_W'(OFS_LVL_CLR));
    assign wr_drv_on  = reg_wen && (reg_addr == ADDR_W'(OFS_DRV_ON));
    assign wr_drv_off = reg_wen && (reg_addr == ADDR_W'(OFS_DRV_OFF));

    assert_level_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lvl_set |=> (pin_out == ($past(pin_out) | $past(reg_wdata))));

    assert_level_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lvl_clr |=> (pin_out == ($past(pin_out) & ~$past(reg_wdata))));

    assert_drive_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_drv_on |=> (pin_oe == ($past(pin_oe) | $past(reg_wdata))));

    assert_drive_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_drv_off |=> (pin_oe == ($past(pin_oe) & ~$past(reg_wdata))));

    assert_read_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(OFS_LVL_SET)) |-> (reg_rdata == pin_out));

    assert_read_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(OFS_DRV_ON)) |-> (reg_rdata == pin_oe));

    assert_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_addr != ADDR_W'(OFS_LVL_SET)) && (reg_addr != ADDR_W'(OFS_DRV_ON)) &&
         (reg_addr != ADDR_W'(OFS_PINS))) |-> (reg_rdata == '0));

    assert_level_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_lvl_set || wr_lvl_clr) |=> $stable(pin_out));

    assert_drive_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_drv_on || wr_drv_off) |=> $stable(pin_oe));

endmodule

// File: tb/sim_setclr_gpio_port.sv
module sim_setclr_gpio_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic        reg_wen = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] exp_out = '0;
    logic [31:0] exp_oe  = '0;
    logic [31:0] seed    = 32'h1234_5678;

    always #4 clk = ~clk;

    setclr_gpio_port u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wen   (reg_wen),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    function automatic logic [31:0] lcg(input logic [31:0] x);
        return x * 32'd1664525 + 32'd1013904223;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wen   = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0;
        case (a)
            8'h00: exp_out = exp_out | d;
            8'h10: exp_out = exp_out & ~d;
            8'h20: exp_oe  = exp_oe | d;
            8'h30: exp_oe  = exp_oe & ~d;
            default: ;
        endcase
    endtask

    task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic check_vectors(input string req);
        check({req, " pin_out"}, pin_out, exp_out);
        check({req, " pin_oe"}, pin_oe, exp_oe);
    endtask

    function automatic logic [31:0] rd_model(input logic [7:0] a);
        case (a)
            8'h00:   return exp_out;
            8'h20:   return exp_oe;
            8'h40:   return pin_in;
            default: return 32'h0;
        endcase
    endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 pin_out in reset", pin_out, 32'h0);
        check("R1 pin_oe in reset", pin_oe, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 pin_out after reset", pin_out, 32'h0);
        check("R1 pin_oe after reset", pin_oe, 32'h0);
        rd("R1 read level", 8'h00, 32'h0);
        rd("R1 read drive", 8'h20, 32'h0);

        // R2/R4/R9: walking one raises each pin and each driver
        for (int i = 0; i < 32; i++) begin
            wr(8'h00, 32'(1) << i);
            check_vectors("R2 R9 walk set");
            wr(8'h20, 32'(1) << i);
            check_vectors("R4 R9 walk enable");
        end
        check("R2 all high", pin_out, 32'hFFFF_FFFF);
        // R3/R5: walking one lowers them again
        for (int i = 0; i < 32; i++) begin
            wr(8'h10, 32'(1) << i);
            check_vectors("R3 R9 walk clear");
            wr(8'h30, 32'(1) << i);
            check_vectors("R5 R9 walk release");
        end
        check("R3 all low", pin_out, 32'h0);
        check("R5 all released", pin_oe, 32'h0);

        // R2-R5, R7: pseudo-random masks on all four update registers
        for (int k = 0; k < 400; k++) begin
            logic [7:0] a;
            seed = lcg(seed);
            a = {2'b00, seed[31:30], 4'h0};
            seed = lcg(seed);
            wr(a, seed);
            check_vectors("R2 R3 R4 R5 random");
            rd("R7 read level", 8'h00, exp_out);
            rd("R7 read drive", 8'h20, exp_oe);
        end

        // R8: read sweep over every address, inputs held steady
        pin_in = 32'hA5C3_0F96;
        repeat (3) @(negedge clk);
        for (int a = 0; a < 256; a++) begin
            rd("R7 R8 read sweep", 8'(a), rd_model(8'(a)));
        end

        // R8: writes to unmapped addresses and to 0x40 change nothing
        for (int a = 0; a < 256; a++) begin
            if (a != 8'h00 && a != 8'h10 && a != 8'h20 && a != 8'h30) begin
                @(negedge clk);
                seed = lcg(seed);
                wr(8'(a), (a[0]) ? 32'hFFFF_FFFF : seed);
                check_vectors("R8 ignored write");
            end
        end

        // R6: two-edge input latency, with drivers both off and on
        wr(8'h30, 32'hFFFF_FFFF);
        for (int k = 0; k < 40; k++) begin
            logic [31:0] old_v, new_v;
            if (k == 20) wr(8'h20, 32'hFFFF_FFFF);
            old_v = pin_in;
            seed  = lcg(seed);
            new_v = (k == 0) ? ~old_v : seed;
            pin_in = new_v;
            rd("R6 before first edge", 8'h40, old_v);
            @(negedge clk);
            rd("R6 after one edge", 8'h40, old_v);
            @(negedge clk);
            rd("R6 after two edges", 8'h40, new_v);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule